// File: doc/BRIEF.md
# Cycle-by-Cycle Current Limiter with Leading-Edge Blanking

This block sits between the bridge steering generator and the drive outputs of a switching converter controller. It sees each active lower-switch pulse as a level from the steering logic. It also sees a digital flag from an analog over-current comparator. The flag is unreliable at the start of every pulse, because switching spikes ring on the sense line. For that reason the flag is masked for a fixed blanking window, counted in clock cycles from the first cycle of each pulse. Once the window has passed, the flag asserting while the pulse is still active cuts that pulse short through a combinational terminate request, issued in the same cycle.

An over-current is not a fault. It only shortens the present pulse, and the next pulse is treated exactly like any other, with no lockout, shutdown or restart. Every pulse end produces a one-cycle clear strobe that discharges the sense and ramp nodes. The strobe fires whether a termination or the steering logic ended the pulse. The blanking length is derived from a time and a clock period given as parameters, rounded up to whole cycles.

Top module: `current_limiter`

## Requirements
- R1: While rst_ni is low, term_o and clr_o are 0.
- R2: In the first BLANK_CYC cycles of a pulse (cycle indices 0 to BLANK_CYC-1, with index 0 being the first cycle in which pulse_act_i is 1 after a cycle in which it was 0), oc_flag_i has no effect and term_o stays 0.
- R3: In any pulse cycle with index BLANK_CYC or higher, oc_flag_i at 1 drives term_o to 1 in that same cycle, with no register between the flag and the output, provided no termination has yet occurred in this pulse.
- R4: term_o is 1 for at most one cycle per pulse. A flag that stays high or re-asserts later in the same pulse produces no further request.
- R5: A flag that rises and falls entirely within the blanking window causes no termination. A flag that is already high when blanking ends terminates the pulse in cycle index BLANK_CYC exactly.
- R6: With pulse_act_i at 0, oc_flag_i has no effect: term_o stays 0.
- R7: A termination causes no lasting state. The next pulse is blanked and limited exactly like the first.
- R8: In the cycle where term_o is 1, clr_o is also 1 for that one cycle.
- R9: When a pulse ends without a termination, clr_o is 1 in the first cycle in which pulse_act_i is 0, and only then. When the pulse was terminated, its later fall produces no second strobe.
- R10: BLANK_CYC equals the ceiling of BLANK_PS / CLK_PERIOD_PS (18 at the defaults of 70000 and 4000). Pulses separated by a single low cycle are each blanked afresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pulse_act_i | input | 1 | Lower-switch pulse active, from the steering generator |
| oc_flag_i | input | 1 | Over-current comparator flag |
| term_o | output | 1 | Request to end the present pulse now (one cycle) |
| clr_o | output | 1 | One-cycle discharge strobe for the sense and ramp nodes |

## Verification
The case that needs the most care is blanking expiry landing in the same cycle as a live flag. Here the end of the mask and the termination must line up on cycle index BLANK_CYC, and the clear strobe must fire in that same cycle rather than one later. The bench provokes this in two ways: with a flag held high from the first cycle of a pulse, and with a flag that first rises in exactly that cycle. It checks term_o and clr_o on every cycle of each pulse and the gap after it. A pulse that is exactly BLANK_CYC cycles long with the flag high throughout is the opposite boundary, where the pulse ending and the window opening meet. It must yield a natural-end strobe and no termination.

// File: rtl/cl_pkg.sv
package cl_pkg;
  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction
endpackage

// File: rtl/cl_blank_timer.sv
module cl_blank_timer #(
  parameter int BLANK_CYC = 18
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic act_i,
  output logic open_o
);
  generate
    if (BLANK_CYC == 0) begin : g_no_blank
      assign open_o = act_i;
    end else begin : g_blank
      localparam int AW = $clog2(BLANK_CYC + 1);
      localparam logic [AW-1:0] LIM = AW'(BLANK_CYC);
      logic [AW-1:0] age_q;
      // age_q holds the index of the current pulse cycle, saturating at LIM
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)          age_q <= '0;
        else if (!act_i)      age_q <= '0;
        else if (age_q < LIM) age_q <= age_q + 1'b1;
      end
      assign open_o = act_i && (age_q >= LIM);
    end
  endgenerate
endmodule

// File: rtl/cl_term_gate.sv
module cl_term_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic act_i,
  input  logic flag_i,
  input  logic open_i,
  output logic term_o,
  output logic done_o
);
  logic done_q;
  // flag reaches term_o combinationally: pulse cut in the same cycle
  assign term_o = open_i && flag_i && !done_q;
  assign done_o = done_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     done_q <= 1'b0;
    else if (!act_i) done_q <= 1'b0;
    else if (term_o) done_q <= 1'b1;
  end
endmodule

// File: rtl/cl_clear_strobe.sv
module cl_clear_strobe (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic act_i,
  input  logic term_i,
  input  logic done_i,
  output logic clr_o
);
  logic act_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_q <= 1'b0;
    else         act_q <= act_i;
  end
  // strobe at termination, or at a natural fall not already handled
  assign clr_o = term_i || (act_q && !act_i && !done_i);
endmodule

// File: rtl/current_limiter.sv
module current_limiter #(
  parameter int CLK_PERIOD_PS = 4000,
  parameter int BLANK_PS      = 70000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pulse_act_i,
  input  logic oc_flag_i,
  output logic term_o,
  output logic clr_o
);
  localparam int BLANK_CYC = cl_pkg::ceil_div(BLANK_PS, CLK_PERIOD_PS);

  logic open_w, term_w, done_w;

  cl_blank_timer #(.BLANK_CYC(BLANK_CYC)) u_blank (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .act_i (pulse_act_i),
    .open_o(open_w)
  );

  cl_term_gate u_gate (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .act_i (pulse_act_i),
    .flag_i(oc_flag_i),
    .open_i(open_w),
    .term_o(term_w),
    .done_o(done_w)
  );

  cl_clear_strobe u_clr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .act_i (pulse_act_i),
    .term_i(term_w),
    .done_i(done_w),
    .clr_o (clr_o)
  );

  assign term_o = term_w;
endmodule

// File: rtl/cl_limit_chk.sv
module cl_limit_chk #(
  parameter int BLANK_CYC = 18
) (
  input logic clk_i,
  input logic rst_ni,
  input logic pulse_act_i,
  input logic oc_flag_i,
  input logic term_o,
  input logic clr_o
);
  int   idx_q;
  logic fired_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q   <= 0;
      fired_q <= 1'b0;
    end else if (!pulse_act_i) begin
      idx_q   <= 0;
      fired_q <= 1'b0;
    end else begin
      if (idx_q < BLANK_CYC) idx_q <= idx_q + 1;
      if (term_o) fired_q <= 1'b1;
    end
  end

  // R2
  blank_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_act_i && idx_q < BLANK_CYC) |-> !term_o);
  // R3
  limit_cut_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_act_i && oc_flag_i && idx_q >= BLANK_CYC && !fired_q) |-> term_o);
  // R4
  single_term_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    term_o |=> !term_o);
  // R6
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pulse_act_i |-> !term_o);
  // R8
  term_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    term_o |-> clr_o);
  // R9
  fall_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_o && !term_o) |-> (!pulse_act_i && $past(pulse_act_i) && !fired_q));
endmodule

bind current_limiter cl_limit_chk #(.BLANK_CYC(BLANK_CYC)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pulse_act_i(pulse_act_i),
  .oc_flag_i  (oc_flag_i),
  .term_o     (term_o),
  .clr_o      (clr_o)
);

// File: tb/current_limiter_bench.sv
module current_limiter_bench;
  localparam int CLK_PS   = 4000;
  localparam int BLANK_PS = 70000;
  localparam int B        = (BLANK_PS + CLK_PS - 1) / CLK_PS; // R10: 18
  localparam int NONE     = -1;

  typedef struct packed {
    int len; int f_on; int f_off; int e_term; int e_clr; int req;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t TBL [NV] = '{
    '{30, 99,    99,    NONE,  30,    9},  // R9 natural end, no flag
    '{30, 5,     10,    NONE,  30,    5},  // R5 flag only inside blanking
    '{30, 5,     25,    B,     B,     5},  // R5 flag held across window edge
    '{30, B+4,   B+6,   B+4,   B+4,   3},  // R3 late flag
    '{30, B,     B+1,   B,     B,     3},  // R3 flag exactly at first open cycle
    '{B,  0,     B,     NONE,  B,     2},  // R2 pulse ends as window would open
    '{B+1,B-1,   B+1,   B,     B,     8},  // R8 terminate on last pulse cycle
    '{30, B+2,   30,    B+2,   B+2,   4},  // R4 held flag, single request
    '{30, B+2,   30,    B+2,   B+2,   7}   // R7 back-to-back, same result
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic act = 1'b0;
  logic flag = 1'b0;
  logic term, clr;
  int   n_chk = 0;
  int   n_bad = 0;

  always #2 clk = ~clk;

  current_limiter #(.CLK_PERIOD_PS(CLK_PS), .BLANK_PS(BLANK_PS)) u_current_limiter (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .pulse_act_i(act),
    .oc_flag_i  (flag),
    .term_o     (term),
    .clr_o      (clr)
  );

  task automatic chk(input string rq, input string what, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b at %0t", rq, what, got, exp, $time);
    end
  endtask

  task automatic step(input logic a, input logic f);
    @(negedge clk);
    act  = a;
    flag = f;
    #1;
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    // R1 reset state, with inputs active during reset
    act = 1'b1; flag = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "term_o", term, 1'b0);
    chk("R1", "clr_o", clr, 1'b0);
    step(1'b0, 1'b0);
    rst_n = 1'b1;
    repeat (3) step(1'b0, 1'b0);

    // R10 window length check on bench constant
    chk("R10", "blank cycles", (B == 18), 1'b1);

    // vector walk: every cycle of each pulse plus the low gap
    for (int e = 0; e < NV; e++) begin
      for (int c = 0; c <= TBL[e].len + 1; c++) begin
        step(c < TBL[e].len,
             (c < TBL[e].len) && (c >= TBL[e].f_on) && (c < TBL[e].f_off));
        chk($sformatf("R%0d", TBL[e].req), "term_o", term, c == TBL[e].e_term);
        chk($sformatf("R%0d", TBL[e].req), "clr_o", clr, c == TBL[e].e_clr);
      end
    end

    // R6 flag with no pulse
    for (int c = 0; c < 5; c++) begin
      step(1'b0, 1'b1);
      chk("R6", "term_o idle", term, 1'b0);
      chk("R6", "clr_o idle", clr, 1'b0);
    end

    // R7 flag high through two pulses separated by one low cycle: both limited
    for (int p = 0; p < 2; p++) begin
      for (int c = 0; c <= B + 3; c++) begin
        step(c < B + 3, 1'b1);
        chk("R7", "term_o repeat", term, c == B);
        chk("R7", "clr_o repeat", clr, c == B);
      end
    end

    // R4 flag drops and re-asserts after a termination
    for (int c = 0; c <= 30; c++) begin
      step(c < 30, (c == B + 1) || (c >= B + 5 && c < B + 8));
      chk("R4", "term_o reassert", term, c == B + 1);
    end
    step(1'b0, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule